// File: doc/BRIEF.md
# Symbol-Timing Drift Clock-Offset Estimator

This block watches the integer FFT-window position that a symbol-timing stage reports once per OFDM symbol and turns the motion of that position into a sample clock offset estimate. Each new position is compared with the one before it. The difference is taken modulo the symbol length and folded into a signed range centred on zero, so a window that slides across the symbol boundary reads as a small step and not as a jump of nearly a whole symbol. The last N differences are held in a circular buffer, and a running sum is updated with the newest entry minus the oldest.

Two views of the running sum are produced. The first is the offset in Hz: one sample of drift per symbol equals 12 kHz, so the estimate is 12000 times the sum divided by N. A positive value means the window moves later, which means the receiver clock runs fast. The second is a signed fixed-point control word with 32 fraction bits. It gives the mean drift per symbol divided by the symbol length, which is the fractional delay per sample that a downstream resampler accumulates. Defaults: symbol length 2560 samples (a 512-sample prefix plus a 2048-point FFT) and N = 128.

Estimates enter on a valid/ready stream. The block never applies back-pressure: `in_ready` is high whenever reset is released, and a beat is taken on every clock edge where `in_valid` is high. The outputs are plain status levels, not a stream.

Top module: `drift_clock_est`

## Requirements
- R1: `in_ready` is 1 in every cycle outside reset, and each cycle with `in_valid` high consumes exactly one position estimate.
- R2: The first estimate after reset only sets the reference position and forms no difference. `est_valid` stays 0 until N differences have been collected, which takes N+1 estimates. It then stays 1 until the next reset.
- R3: Each difference is (new − previous) folded into (−P/2, +P/2]. A raw difference above P/2 has P subtracted. A raw difference at or below −P/2 has P added. A raw difference of exactly −P/2 therefore reads as +P/2.
- R4: `est_hz` is a signed two's-complement value equal to floor(12000·S/N), where S is the sum of the most recent N differences. Slots not yet filled since reset count as 0. When a new difference enters a full window, the oldest one leaves it.
- R5: `est_ctrl` is a signed two's-complement value of FRAC_W+2 bits, with FRAC_W = 32 fraction bits. It equals S·2^FRAC_W / (N·P), truncated toward zero.
- R6: A window that drifts later gives a positive `est_hz` and a non-negative `est_ctrl`. A window that drifts earlier gives a negative `est_hz` and a non-positive `est_ctrl`. Zero drift gives zero on both outputs.
- R7: In a cycle with `in_valid` low, the outputs keep their values.
- R8: While `rst_n` is low, `est_valid`, `est_hz` and `est_ctrl` are 0, and the stored history is cleared.
- R9: An estimate taken at a clock edge changes the outputs right after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A position estimate is present on `in_pos` |
| in_ready | output | 1 | Estimate accepted; high whenever reset is released |
| in_pos | input | POS_W | FFT-window position, 0 to P−1 |
| est_valid | output | 1 | N differences have been collected since reset |
| est_hz | output | HZ_W | Clock-offset estimate in Hz, signed |
| est_ctrl | output | FRAC_W+2 | Fractional delay per sample, signed, FRAC_W fraction bits |

## Verification
The bench builds the block with N = 8 (N_LOG2 = 3) and keeps the full 2560-sample symbol. The short window lets the fill phase, the slide-out of old differences and a complete change of drift direction each happen within a few estimates. The real symbol length keeps the boundary crossings and the exact −P/2 fold case realistic. With N = 8, the Hz output is an exact multiple of 1500, and the control word lands on fractions that need truncation in both signs.

// File: rtl/drift_est_pkg.sv
package drift_est_pkg;
  // Offset in Hz that corresponds to one whole sample of drift per symbol.
  localparam longint HZ_PER_SAMPLE_STEP = 64'sd12000;
endpackage

// File: rtl/drift_delta.sv
// Keeps the previous window position and forms the folded symbol-to-symbol step.
module drift_delta #(
  parameter int POS_W  = 12,
  parameter int P      = 2560,
  parameter int DIFF_W = POS_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic [POS_W-1:0]         pos,
  output logic signed [DIFF_W-1:0] delta,
  output logic                     have_ref
);
  localparam int RW = POS_W + 2;
  localparam logic signed [RW-1:0] HALF_S = RW'(P / 2);
  localparam logic signed [RW-1:0] SYM_S  = RW'(P);

  logic [POS_W-1:0]     ref_pos;
  logic signed [RW-1:0] raw;
  logic signed [RW-1:0] folded;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_pos  <= '0;
      have_ref <= 1'b0;
    end else if (take) begin
      ref_pos  <= pos;
      have_ref <= 1'b1;
    end
  end

  always_comb begin
    raw = $signed({2'b00, pos}) - $signed({2'b00, ref_pos});
    if (raw > HALF_S)
      folded = raw - SYM_S;
    else if (raw <= -HALF_S)
      folded = raw + SYM_S;
    else
      folded = raw;
  end

  assign delta = DIFF_W'(folded);
endmodule

// File: rtl/drift_window.sv
// Circular store of the last N steps with a running sum.
module drift_window #(
  parameter int DIFF_W = 13,
  parameter int N_LOG2 = 7,
  parameter int SUM_W  = DIFF_W + N_LOG2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic signed [DIFF_W-1:0] delta,
  output logic signed [SUM_W-1:0]  sum,
  output logic                     full
);
  localparam int N = 1 << N_LOG2;

  logic signed [DIFF_W-1:0] ring [N];
  logic [N_LOG2-1:0]        wp;
  logic [N_LOG2:0]          fill;
  logic signed [SUM_W-1:0]  sum_nxt;

  assign sum_nxt = sum + SUM_W'(delta) - SUM_W'(ring[wp]);
  assign full    = fill[N_LOG2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ring[i] <= '0;
      wp   <= '0;
      fill <= '0;
      sum  <= '0;
    end else if (push) begin
      ring[wp] <= delta;
      wp       <= wp + 1'b1;
      sum      <= sum_nxt;
      if (!fill[N_LOG2]) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/drift_scale.sv
// Turns the running sum into Hz and into fractional delay per sample.
module drift_scale
  import drift_est_pkg::*;
#(
  parameter int SUM_W  = 20,
  parameter int N_LOG2 = 7,
  parameter int P      = 2560,
  parameter int FRAC_W = 32,
  parameter int HZ_W   = 32,
  parameter int CTRL_W = FRAC_W + 2
) (
  input  logic signed [SUM_W-1:0]  sum,
  output logic signed [HZ_W-1:0]   est_hz,
  output logic signed [CTRL_W-1:0] est_ctrl
);
  localparam logic signed [63:0] DEN = 64'(longint'(P) << N_LOG2);

  logic signed [63:0] s_ext;
  logic signed [63:0] prod;
  logic signed [63:0] quo;

  assign s_ext    = {{(64 - SUM_W){sum[SUM_W-1]}}, sum};
  assign prod     = s_ext * HZ_PER_SAMPLE_STEP;
  assign est_hz   = HZ_W'(prod >>> N_LOG2);
  assign quo      = (s_ext <<< FRAC_W) / DEN;
  assign est_ctrl = CTRL_W'(quo);
endmodule

// File: rtl/drift_clock_est.sv
module drift_clock_est #(
  parameter int POS_W  = 12,
  parameter int P      = 2560,
  parameter int N_LOG2 = 7,
  parameter int FRAC_W = 32,
  parameter int HZ_W   = 32,
  localparam int CTRL_W = FRAC_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [POS_W-1:0]         in_pos,
  output logic                     est_valid,
  output logic signed [HZ_W-1:0]   est_hz,
  output logic signed [CTRL_W-1:0] est_ctrl
);
  localparam int DIFF_W = POS_W + 1;
  localparam int SUM_W  = DIFF_W + N_LOG2;

  logic                     take;
  logic                     have_ref;
  logic signed [DIFF_W-1:0] delta;
  logic signed [SUM_W-1:0]  sum;

  assign in_ready = rst_n;
  assign take     = in_valid & in_ready;

  drift_delta #(.POS_W(POS_W), .P(P), .DIFF_W(DIFF_W)) u_delta (
    .clk(clk), .rst_n(rst_n), .take(take), .pos(in_pos),
    .delta(delta), .have_ref(have_ref)
  );

  drift_window #(.DIFF_W(DIFF_W), .N_LOG2(N_LOG2), .SUM_W(SUM_W)) u_window (
    .clk(clk), .rst_n(rst_n), .push(take & have_ref), .delta(delta),
    .sum(sum), .full(est_valid)
  );

  drift_scale #(.SUM_W(SUM_W), .N_LOG2(N_LOG2), .P(P), .FRAC_W(FRAC_W),
                .HZ_W(HZ_W), .CTRL_W(CTRL_W)) u_scale (
    .sum(sum), .est_hz(est_hz), .est_ctrl(est_ctrl)
  );
endmodule

// File: rtl/drift_clock_est_chk.sv
module drift_clock_est_chk #(
  parameter int N_LOG2 = 7,
  parameter int HZ_W   = 32,
  parameter int CTRL_W = 34
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     est_valid,
  input logic signed [HZ_W-1:0]   est_hz,
  input logic signed [CTRL_W-1:0] est_ctrl
);
  localparam logic [N_LOG2+1:0] LIM = (N_LOG2+2)'((1 << N_LOG2) + 1);
  logic [N_LOG2+1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (in_valid && in_ready && seen != LIM) seen <= seen + 1'b1;
  end

  assert_valid_after_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid == (seen == LIM));

  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |=> est_valid);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(est_hz) && $stable(est_ctrl)));

  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

  assert_sign_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (est_hz > 0) |-> (est_ctrl >= 0));

  assert_sign_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (est_hz < 0) |-> (est_ctrl <= 0));

  assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (est_hz == 0) |-> (est_ctrl == 0));
endmodule

bind drift_clock_est drift_clock_est_chk #(
  .N_LOG2(N_LOG2), .HZ_W(HZ_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .est_valid(est_valid), .est_hz(est_hz), .est_ctrl(est_ctrl)
);

// File: tb/drift_clock_est_tb.sv
module drift_clock_est_tb;
  localparam int POS_W  = 12;
  localparam int P      = 2560;
  localparam int N_LOG2 = 3;
  localparam int N      = 1 << N_LOG2;
  localparam int FRAC_W = 32;
  localparam int HZ_W   = 32;
  localparam int CTRL_W = FRAC_W + 2;

  // Stimulus positions and the folded step each one should produce (R3).
  localparam int VEC_N = 13;
  localparam int VPOS [VEC_N] = '{100, 101, 103, 103, 2559, 5, 2555, 1275, 0, 1280, 1281, 1281, 1282};
  localparam int VDIF [VEC_N] = '{0,   1,   2,   0,   -104, 6, -10,  1280, -1275, 1280, 1, 0, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [POS_W-1:0] in_pos = '0;
  logic est_valid;
  logic signed [HZ_W-1:0] est_hz;
  logic signed [CTRL_W-1:0] est_ctrl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Model of the requirements.
  longint ring [N];
  int wp = 0;
  int nd = 0;

  always #5 clk = ~clk;

  drift_clock_est #(.POS_W(POS_W), .P(P), .N_LOG2(N_LOG2), .FRAC_W(FRAC_W), .HZ_W(HZ_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pos(in_pos),
    .est_valid(est_valid), .est_hz(est_hz), .est_ctrl(est_ctrl)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mdl_clear();
    for (int i = 0; i < N; i++) ring[i] = 0;
    wp = 0;
    nd = 0;
  endtask

  task automatic mdl_push(input longint d);
    ring[wp] = d;
    wp = (wp + 1) % N;
    if (nd < N) nd++;
  endtask

  function automatic longint mdl_sum();
    longint s = 0;
    for (int i = 0; i < N; i++) s += ring[i];
    return s;
  endfunction

  function automatic longint exp_hz();
    return (mdl_sum() * 12000) >>> N_LOG2;
  endfunction

  function automatic longint exp_ctrl();
    return (mdl_sum() <<< FRAC_W) / longint'(N * P);
  endfunction

  task automatic check_all(input string tag);
    check({tag, " R2 valid"}, longint'(est_valid), longint'(nd == N));
    check({tag, " R4 hz"}, longint'(est_hz), exp_hz());
    check({tag, " R5 ctrl"}, longint'(est_ctrl), exp_ctrl());
  endtask

  // Drive at a falling edge, accept on the rising edge, check at the next falling edge.
  task automatic send(input int pos, input bit first, input longint d);
    longint old_hz;
    old_hz = exp_hz();
    in_valid = 1'b1;
    in_pos = POS_W'(pos);
    #1;
    check("R9 before edge hz", longint'(est_hz), old_hz);
    check("R1 ready", longint'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    if (!first) mdl_push(d);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    mdl_clear();
    repeat (2) @(negedge clk);
    check("R8 valid in reset", longint'(est_valid), 0);
    check("R8 hz in reset", longint'(est_hz), 0);
    check("R8 ctrl in reset", longint'(est_ctrl), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    mdl_clear();
    @(negedge clk);
    do_reset();

    // Table walk: fill phase, boundary folds, slide-out of old steps.
    for (int i = 0; i < VEC_N; i++) begin
      send(VPOS[i], i == 0, longint'(VDIF[i]));
      check_all($sformatf("R3 vec%0d", i));
    end

    // R7: idle cycles leave the outputs alone.
    begin
      longint h;
      longint c;
      h = longint'(est_hz);
      c = longint'(est_ctrl);
      repeat (5) @(negedge clk);
      check("R7 idle hz", longint'(est_hz), h);
      check("R7 idle ctrl", longint'(est_ctrl), c);
      check("R7 idle valid", longint'(est_valid), 1);
    end

    // R8/R2: reset mid-run clears history; first estimate only sets the reference.
    do_reset();
    send(2555, 1'b1, 0);
    check_all("R2 after reset first");
    // R6: steady later drift across the boundary, +1 per symbol.
    for (int i = 1; i <= N; i++) begin
      send((2555 + i) % P, 1'b0, 1);
      check_all("R6 plus drift");
    end
    check("R6 plus hz", longint'(est_hz), 12000);
    check("R6 plus ctrl", longint'(est_ctrl), 1677721);
    // R6: drift reverses; window flushes to -1 per symbol.
    for (int i = 1; i <= N; i++) begin
      send((2555 + N - i + P) % P, 1'b0, -1);
      check_all("R6 minus drift");
    end
    check("R6 minus hz", longint'(est_hz), -12000);
    check("R6 minus ctrl", longint'(est_ctrl), -1677721);
    // R5: one net sample over the window, truncation toward zero.
    send((2555 + N - N) % P, 1'b0, 0);
    for (int i = 0; i < N - 1; i++) begin
      send((2555 + 1) % P, 1'b0, (i == 0) ? 1 : 0);
    end
    check_all("R5 small");
    check("R5 small hz", longint'(est_hz), 1500);
    check("R5 small ctrl", longint'(est_ctrl), 209715);
    // Zero drift gives zero outputs (R6).
    for (int i = 0; i < N; i++) send(2556, 1'b0, 0);
    check("R6 zero hz", longint'(est_hz), 0);
    check("R6 zero ctrl", longint'(est_ctrl), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule